// File: doc/BRIEF.md
# Cipher Accelerator Control and Status Registers

This block holds the control and status word of a block-cipher accelerator. Software uses a simple word-addressed register bus with an address, a write strobe, write data and combinational read data. The control word selects the chaining mode, the operating mode and the data swap format, and it carries the enable bit. It also has two write-one-to-clear command bits, one for the completion flag and one for the error flags. The status word gathers events from the cipher core into sticky flags.

The block sends the cipher core a resolved, effective operating mode. When the key-derivation-then-decrypt mode is requested under counter chaining, the core is told to run a plain decrypt. While the engine is enabled, the block refuses all configuration changes. The enable bit is held by a two-state machine with these states:
- `EN_OFF`
- `EN_ON`

The machine has three named transitions:
- `T_START`: a control write with bit 0 set while in `EN_OFF`.
- `T_STOP`: a control write with bit 0 clear while in `EN_ON`.
- `T_KEYDONE`: the core reports key preparation finished while in `EN_ON` and the effective mode is key derivation.

Every other case holds the state. On `T_START` the block raises a one-cycle re-initialize pulse to the core.

Top module: `cph_ctl_regs`

## Requirements
- R1: After reset the enable is 0, chaining, operating mode and swap fields are 00, all status flags are 0 and the re-initialize pulse is low.
- R2: The control word (index 0) reads enable at bit 0, swap at bits 2:1, operating mode at bits 4:3 and chaining at bits 6:5; bits 7, 8 and all upper bits read 0.
- R3: While enable is 1, writes to the chaining, operating mode and swap fields are ignored and the old values kept.
- R4: A write of 11 to the chaining field (00 ECB, 01 CBC, 10 counter) leaves the chaining field unchanged.
- R5: The effective mode output equals the stored mode (00 encrypt, 01 key derivation, 10 decrypt, 11 key derivation then decrypt), except that a stored 11 with chaining 10 gives effective mode 10.
- R6: A write requesting mode 10 while the stored mode is 11 leaves the mode at 11; other fields of that write still apply.
- R7: Enable may be written at any time. A 0-to-1 change raises the re-initialize output for exactly one cycle, in the first cycle enable reads 1.
- R8: A key-preparation-done event while enable is 1 and the effective mode is 01 clears enable on the next cycle. This wins over a same-cycle write of enable 1. In other modes the event has no effect.
- R9: Completion, read-error and write-error events set sticky flags, read at status word (index 1) bits 0, 1 and 2.
- R10: A control write with bit 7 set clears the completion flag, and one with bit 8 set clears both error flags; writing 0 to these bits leaves the flags unchanged.
- R11: An event arriving in the same cycle as its clear command leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word index of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| core_ccf_i | input | 1 | Computation complete event |
| core_rderr_i | input | 1 | Read error event |
| core_wrerr_i | input | 1 | Write error event |
| core_keydone_i | input | 1 | Key preparation finished event |
| en_o | output | 1 | Engine enable |
| chain_o | output | 2 | Chaining mode |
| mode_o | output | 2 | Effective operating mode |
| swap_o | output | 2 | Data swap format |
| reinit_o | output | 1 | One-cycle re-initialize pulse |

## Verification
On every cycle, the assertions check the following:
- The configuration stays frozen while enabled.
- The reserved chaining code never enters the field.
- Decrypt never directly follows mode 11.
- The re-initialize pulse is single-cycle and tied to the enable rise.
- The key-done exit is taken.
- The flags obey set-over-clear.

Only the bench's scenarios can show a number of things. These are the exact readback layout, the resolved mode for every field combination across full sweeps in two orders, and that writing 0 to the clear bits spares the flags. They also include the full enable, disable and re-enable sequence as seen at the ports.

// File: rtl/cph_ctl_pkg.sv
package cph_ctl_pkg;

    typedef enum logic [1:0] {CHN_ECB, CHN_CBC, CHN_CTR, CHN_RSV} chain_e;
    typedef enum logic [1:0] {OPM_ENC, OPM_KEYDRV, OPM_DEC, OPM_KEYDEC} opmode_e;
    typedef enum logic [1:0] {SWP_NONE, SWP_HALF, SWP_BYTE, SWP_BIT} swap_e;
    typedef enum logic {EN_OFF, EN_ON} en_state_e;

    localparam int EN_BIT   = 0;
    localparam int SWP_LSB  = 1;
    localparam int OPM_LSB  = 3;
    localparam int CHN_LSB  = 5;
    localparam int CCLR_BIT = 7;
    localparam int ECLR_BIT = 8;
    localparam int CTRL_USED_W = ECLR_BIT + 1;

    localparam int FLG_CCF   = 0;
    localparam int FLG_RDERR = 1;
    localparam int FLG_WRERR = 2;
    localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/cph_ctl_fsm.sv
module cph_ctl_fsm
    import cph_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_i,
    input  logic en_wdata_i,
    input  logic kp_clear_i,
    output logic en_o,
    output logic reinit_o
);

    en_state_e state_q, state_d;
    logic      reinit_q;

    // next state: T_START, T_STOP, T_KEYDONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_OFF: begin
                if (ctl_wr_i && en_wdata_i) begin
                    state_d = EN_ON;            // T_START
                end
            end
            EN_ON: begin
                if (kp_clear_i) begin
                    state_d = EN_OFF;           // T_KEYDONE
                end else if (ctl_wr_i && !en_wdata_i) begin
                    state_d = EN_OFF;           // T_STOP
                end
            end
            default: state_d = EN_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // output register: one-cycle pulse on T_START
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reinit_q <= 1'b0;
        end else begin
            reinit_q <= (state_q == EN_OFF) && (state_d == EN_ON);
        end
    end

    assign en_o     = (state_q == EN_ON);
    assign reinit_o = reinit_q;

    p_reinit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_q |=> !reinit_q);

    p_reinit_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EN_OFF && ctl_wr_i && en_wdata_i) |=> (reinit_q && state_q == EN_ON));

    p_keydone_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EN_ON && kp_clear_i) |=> (state_q == EN_OFF && !reinit_q));

endmodule

// File: rtl/cph_ctl_fields.sv
module cph_ctl_fields
    import cph_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_i,
    input  logic    lock_i,
    input  chain_e  chain_w_i,
    input  opmode_e mode_w_i,
    input  swap_e   swap_w_i,
    output chain_e  chain_o,
    output opmode_e mode_o,
    output opmode_e mode_eff_o,
    output swap_e   swap_o
);

    chain_e  chain_q;
    opmode_e mode_q;
    swap_e   swap_q;
    logic    upd;
    logic    chain_ok;
    logic    mode_ok;

    assign upd      = wr_i && !lock_i;
    assign chain_ok = (chain_w_i != CHN_RSV);
    assign mode_ok  = !(mode_q == OPM_KEYDEC && mode_w_i == OPM_DEC);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= CHN_ECB;
            mode_q  <= OPM_ENC;
            swap_q  <= SWP_NONE;
        end else if (upd) begin
            if (chain_ok) begin
                chain_q <= chain_w_i;
            end
            if (mode_ok) begin
                mode_q <= mode_w_i;
            end
            swap_q <= swap_w_i;
        end
    end

    // key-derive-then-decrypt only exists for ECB and CBC chaining
    always_comb begin
        mode_eff_o = mode_q;
        if (mode_q == OPM_KEYDEC && chain_q != CHN_ECB && chain_q != CHN_CBC) begin
            mode_eff_o = OPM_DEC;
        end
    end

    assign chain_o = chain_q;
    assign mode_o  = mode_q;
    assign swap_o  = swap_q;

    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> ($stable(chain_q) && $stable(mode_q) && $stable(swap_q)));

    p_no_rsv_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q != CHN_RSV);

    p_no_dec_after_keydec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OPM_KEYDEC) |=> (mode_q != OPM_DEC));

endmodule

// File: rtl/cph_ctl_flags.sv
module cph_ctl_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else if (set_i[g]) begin
                flag_q[g] <= 1'b1;
            end else if (clr_i[g]) begin
                flag_q[g] <= 1'b0;
            end
        end

        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_q[g]);

        p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_q[g]);

        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/cph_ctl_regs.sv
module cph_ctl_regs
    import cph_ctl_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int CTRL_IDX = 0,
    parameter int STAT_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_ccf_i,
    input  logic              core_rderr_i,
    input  logic              core_wrerr_i,
    input  logic              core_keydone_i,
    output logic              en_o,
    output logic [1:0]        chain_o,
    output logic [1:0]        mode_o,
    output logic [1:0]        swap_o,
    output logic              reinit_o
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_IDX);

    logic           ctl_wr;
    logic           en_q;
    logic           kp_clear;
    chain_e         chain_q;
    opmode_e        mode_q;
    opmode_e        mode_eff;
    swap_e          swap_q;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flags;
    logic [DATA_W-1:0]    ctrl_word;
    logic [DATA_W-1:0]    stat_word;
    logic                 unused_wdata;

    assign ctl_wr   = bus_we && (bus_addr == CTRL_A);
    assign kp_clear = core_keydone_i && (mode_eff == OPM_KEYDRV);
    assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_USED_W];

    cph_ctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr_i   (ctl_wr),
        .en_wdata_i (bus_wdata[EN_BIT]),
        .kp_clear_i (kp_clear),
        .en_o       (en_q),
        .reinit_o   (reinit_o)
    );

    cph_ctl_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ctl_wr),
        .lock_i     (en_q),
        .chain_w_i  (chain_e'(bus_wdata[CHN_LSB +: 2])),
        .mode_w_i   (opmode_e'(bus_wdata[OPM_LSB +: 2])),
        .swap_w_i   (swap_e'(bus_wdata[SWP_LSB +: 2])),
        .chain_o    (chain_q),
        .mode_o     (mode_q),
        .mode_eff_o (mode_eff),
        .swap_o     (swap_q)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLG_CCF]   = core_ccf_i;
        flag_set[FLG_RDERR] = core_rderr_i;
        flag_set[FLG_WRERR] = core_wrerr_i;
        flag_clr            = '0;
        if (ctl_wr) begin
            flag_clr[FLG_CCF]   = bus_wdata[CCLR_BIT];
            flag_clr[FLG_RDERR] = bus_wdata[ECLR_BIT];
            flag_clr[FLG_WRERR] = bus_wdata[ECLR_BIT];
        end
    end

    cph_ctl_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flags)
    );

    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[EN_BIT]          = en_q;
        ctrl_word[SWP_LSB +: 2]    = swap_q;
        ctrl_word[OPM_LSB +: 2]    = mode_q;
        ctrl_word[CHN_LSB +: 2]    = chain_q;
        stat_word                  = '0;
        stat_word[NUM_FLAGS-1:0]   = flags;
        if (bus_addr == CTRL_A) begin
            bus_rdata = ctrl_word;
        end else if (bus_addr == STAT_A) begin
            bus_rdata = stat_word;
        end else begin
            bus_rdata = '0;
        end
    end

    assign en_o    = en_q;
    assign chain_o = chain_q;
    assign mode_o  = mode_eff;
    assign swap_o  = swap_q;

    p_ctr_no_keydec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_o == 2'b10) |-> (mode_o != 2'b11));

    p_reinit_implies_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_o |-> en_o);

endmodule

// File: tb/cph_ctl_regs_tb.sv
module cph_ctl_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          ccf = 1'b0, rderr = 1'b0, wrerr = 1'b0, keydone = 1'b0;
    logic          en_o, reinit_o;
    logic [1:0]    chain_o, mode_o, swap_o;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [1:0] m_chain = 0, m_mode = 0, m_swap = 0;
    logic       m_en = 0;
    logic [2:0] m_flags = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cph_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_ccf_i(ccf), .core_rderr_i(rderr), .core_wrerr_i(wrerr),
        .core_keydone_i(keydone), .en_o(en_o), .chain_o(chain_o),
        .mode_o(mode_o), .swap_o(swap_o), .reinit_o(reinit_o)
    );

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] ctrl_exp();
        return DW'({m_chain, m_mode, m_swap, m_en});
    endfunction

    function automatic logic [1:0] eff_exp();
        return (m_mode == 2'd3 && m_chain == 2'd2) ? 2'd2 : m_mode;
    endfunction

    // model update for a control write (kd: same-cycle key-done)
    task automatic model_wr(input logic [DW-1:0] d, input logic kd);
        logic kp;
        kp = kd && m_en && (eff_exp() == 2'd1);
        if (!m_en) begin
            if (d[6:5] != 2'd3) m_chain = d[6:5];
            if (!(m_mode == 2'd3 && d[4:3] == 2'd2)) m_mode = d[4:3];
            m_swap = d[2:1];
        end
        m_en = kp ? 1'b0 : d[0];
        if (d[7]) m_flags[0] = 1'b0;
        if (d[8]) m_flags[2:1] = 2'b00;
    endtask

    task automatic wr(input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = 0; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_wr(d, 1'b0);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic chk_cfg(input string tag);
        logic [DW-1:0] v;
        rd(0, v);
        chk({tag, " ctrl"}, v, ctrl_exp());
        chk({tag, " mode_o"}, DW'(mode_o), DW'(eff_exp()));
        chk({tag, " chain_o"}, DW'(chain_o), DW'(m_chain));
        chk({tag, " swap_o"}, DW'(swap_o), DW'(m_swap));
        chk({tag, " en_o"}, DW'(en_o), DW'(m_en));
    endtask

    task automatic chk_stat(input string tag);
        logic [DW-1:0] v;
        rd(1, v);
        chk(tag, v, DW'(m_flags));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_cfg("R1 reset");
        chk_stat("R1 status");
        chk("R1 reinit", DW'(reinit_o), 0);

        // R2 R4 R5 sweep in order, enable 0
        for (int i = 0; i < 64; i++) begin
            wr(DW'(i) << 1);
            chk_cfg("R2/R4/R5 sweep");
        end
        // second sweep in permuted order, also with clear bits set (they read 0)
        for (int i = 0; i < 64; i++) begin
            wr((DW'((i * 37) % 64) << 1) | (DW'(i & 3) << 7));
            chk_cfg("R2/R5 permuted sweep");
        end
        wr(32'hFFFF_FE00);
        chk_cfg("R2 upper bits");

        // R6 decrypt not directly after mode 11
        wr({25'd0, 2'd0, 2'd3, 2'd0, 1'b0});
        wr({25'd0, 2'd1, 2'd2, 2'd1, 1'b0});
        chk("R6 mode kept 11", DW'(u_dut.bus_rdata[4:3]), 3);
        chk_cfg("R6 other fields");
        wr({25'd0, 2'd1, 2'd0, 2'd0, 1'b0});
        wr({25'd0, 2'd1, 2'd2, 2'd0, 1'b0});
        chk_cfg("R6 decrypt after encrypt");

        // R5 keydec under counter chaining
        wr({25'd0, 2'd0, 2'd3, 2'd0, 1'b0});
        wr({25'd0, 2'd2, 2'd3, 2'd0, 1'b0});
        chk("R5 ctr keydec eff", DW'(mode_o), 2);
        // R4 reserved chain ignored
        wr({25'd0, 2'd3, 2'd3, 2'd2, 1'b0});
        chk("R4 chain kept", DW'(chain_o), 2);
        chk_cfg("R4 cfg");

        // R7 enable rise pulse
        wr({25'd0, 2'd1, 2'd0, 2'd3, 1'b1});
        chk("R7 reinit pulse", DW'(reinit_o), 1);
        chk_cfg("R7 enabled");
        @(negedge clk);
        chk("R7 pulse one cycle", DW'(reinit_o), 0);

        // R3 lock sweep while enabled
        for (int i = 0; i < 64; i++) begin
            wr((DW'(i) << 1) | 1);
            chk_cfg("R3 locked");
            chk("R3 no reinit", DW'(reinit_o), 0);
        end
        wr({25'd0, 2'd1, 2'd0, 2'd3, 1'b0});
        chk_cfg("R7 disabled");
        chk("R7 no pulse on fall", DW'(reinit_o), 0);
        wr({25'd0, 2'd1, 2'd0, 2'd3, 1'b1});
        chk("R7 re-enable pulse", DW'(reinit_o), 1);

        // R8 key-done in mode 00: no effect
        @(negedge clk); keydone = 1'b1;
        @(negedge clk); keydone = 1'b0;
        chk("R8 keydone mode 00", DW'(en_o), 1);
        wr(0);
        // R8 key-done while disabled in mode 01: no effect, stays off
        wr({25'd0, 2'd0, 2'd1, 2'd0, 1'b0});
        @(negedge clk); keydone = 1'b1;
        @(negedge clk); keydone = 1'b0;
        chk("R8 keydone disabled", DW'(en_o), 0);
        // R8 key-done in mode 01 clears enable
        wr({25'd0, 2'd0, 2'd1, 2'd0, 1'b1});
        @(negedge clk); keydone = 1'b1;
        @(negedge clk); keydone = 1'b0;
        m_en = 1'b0;
        chk_cfg("R8 auto clear");
        // R8 key-done wins over same-cycle enable write
        wr({25'd0, 2'd0, 2'd1, 2'd0, 1'b1});
        @(negedge clk);
        bus_addr = 0; bus_we = 1'b1; bus_wdata = {25'd0, 2'd0, 2'd1, 2'd0, 1'b1}; keydone = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; keydone = 1'b0;
        model_wr({25'd0, 2'd0, 2'd1, 2'd0, 1'b1}, 1'b1);
        chk_cfg("R8 keydone beats write");
        // R8 keydec mode 11 is not key-derivation: no clear
        wr({25'd0, 2'd0, 2'd3, 2'd0, 1'b1});
        @(negedge clk); keydone = 1'b1;
        @(negedge clk); keydone = 1'b0;
        chk("R8 keydone mode 11", DW'(en_o), 1);

        // R9 events set sticky flags
        @(negedge clk); ccf = 1'b1;
        @(negedge clk); ccf = 1'b0; m_flags[0] = 1'b1;
        chk_stat("R9 ccf");
        @(negedge clk); rderr = 1'b1;
        @(negedge clk); rderr = 1'b0; m_flags[1] = 1'b1;
        chk_stat("R9 rderr");
        @(negedge clk); wrerr = 1'b1;
        @(negedge clk); wrerr = 1'b0; m_flags[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk_stat("R9 wrerr sticky");

        // R10 writing 0 to clear bits: no effect
        wr(ctrl_exp());
        chk_stat("R10 zero clear bits");
        wr(ctrl_exp() | (1 << 7));
        chk_stat("R10 clear ccf");
        wr(ctrl_exp() | (1 << 8));
        chk_stat("R10 clear errors");
        chk_cfg("R10 cfg kept");

        // R11 set wins over clear
        @(negedge clk);
        bus_addr = 0; bus_we = 1'b1; bus_wdata = ctrl_exp() | (3 << 7);
        ccf = 1'b1; wrerr = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; ccf = 1'b0; wrerr = 1'b0;
        m_flags = 3'b101;
        chk_stat("R11 set wins");
        rd(1, v);
        chk("R11 rderr cleared", DW'(v[1]), 0);

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_chain = 0; m_mode = 0; m_swap = 0; m_en = 0; m_flags = 0;
        chk_cfg("R1 re-reset");
        chk_stat("R1 re-reset status");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule